// File: doc/BRIEF.md
# Best-Antenna Comparison Sequencer

This block decides which of two antennas delivers the stronger signal during a short measurement window. A window input opens the measurement and a stream of unsigned 8-bit signal-strength samples arrives, one per clock. A fixed clock-count schedule runs from the window's opening. First comes a reset interval in which both trackers are held at zero. Then the peak of the samples is acquired as the first antenna's value. Next is a gap in which that value is held, the second tracker is zeroed and an antenna-swap flag tells the surrounding logic to switch antennas. Last comes a second acquire phase for the other antenna.

The second tracker keeps following its samples for as long as the window stays open. When the window closes, the block registers a one-bit decision. The decision is 1 only when the second antenna's peak is strictly greater than the first. The decision output is forced to 0 at every window opening. A window that closes before the second acquire phase has finished leaves the decision at 0 and raises a one-clock abort pulse. A strobe output mirrors the acquire phases, so it can power the comparison path. The strobe stays high for one clock after the window falls.

Top module: `antsel_seq`

## Requirements
- R1: While reset is applied and after it is released with the window low, best_o, strobe_o, swap_o and abort_o are all 0.
- R2: The clock edge that first sees win_i high after it was low drives best_o to 0 and restarts the schedule. This holds even in the clock that follows a window close.
- R3: Counting k = 0 at the edge that sees the window rise, strobe_o is high after edges k = RST_CYC to RST_CYC+ACQ_CYC-1. It is high again from k = RST_CYC+ACQ_CYC+GAP_CYC while the window stays high. At every other k in the window it is low (defaults: low for k 0..3 and 12..15, high for k 4..11 and from k 16).
- R4: swap_o is high exactly after edges k = RST_CYC+ACQ_CYC to RST_CYC+ACQ_CYC+GAP_CYC-1 (defaults 12..15) and never together with strobe_o.
- R5: The first peak is the largest sample presented at edges k = RST_CYC+1 to RST_CYC+ACQ_CYC (defaults 5..12). Samples at every other edge, including those during the reset interval and the gap, do not alter it.
- R6: The second peak is zeroed during the gap. It then takes the largest sample presented from edge k = RST_CYC+ACQ_CYC+GAP_CYC+1 (default 17) up to the last edge that still sees the window high.
- R7: When the window falls at edge k >= RST_CYC+2*ACQ_CYC+GAP_CYC+1 (default 25), best_o becomes 1 if the second peak is strictly greater than the first, as unsigned 8-bit values. Otherwise it becomes 0, and equal peaks give 0. best_o does not change while the window stays high or stays low.
- R8: When the window falls at an earlier edge (default k <= 24), best_o stays 0 and abort_o is 1 for exactly the one clock after that edge.
- R9: If strobe_o was high when the window fell, it stays high for one more clock and then goes low. If it was low, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_i | input | 1 | Measurement window, high for the whole comparison |
| smp_i | input | SW (8) | Unsigned signal-strength sample, one per clock |
| strobe_o | output | 1 | Acquire-phase strobe; powers the comparison path |
| swap_o | output | 1 | High during the gap: switch to the second antenna |
| best_o | output | 1 | Decision: 0 first antenna stronger or equal, 1 second stronger |
| abort_o | output | 1 | One-clock pulse when the window closes before the second phase ends |

## Verification
The window close and the end of the second acquire phase can fall on the same clock. The bench provokes this by dropping the window so that its last high edge is also the last edge of the second acquire phase. A window one clock shorter must instead give an abort with the decision held at 0. A window reopening can also fall in the tail clock that follows a close. The bench raises the window again in that very clock and judges that a decision of 1 is cleared at once and that the reset interval starts without the tail strobe carrying over.

// File: rtl/antsel_pkg.sv
package antsel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CLR  = 3'd1,
    ST_ACQA = 3'd2,
    ST_GAP  = 3'd3,
    ST_ACQB = 3'd4,
    ST_HOLD = 3'd5,
    ST_TAIL = 3'd6
  } seq_st_e;

endpackage

// File: rtl/antsel_rstsync.sv
module antsel_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn_o = sync_q[1];

endmodule

// File: rtl/antsel_sched.sv
module antsel_sched
  import antsel_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int ACQ_CYC = 8,
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  output logic rise_o,
  output logic strobe_o,
  output logic swap_o,
  output logic clr_a_o,
  output logic en_a_o,
  output logic clr_b_o,
  output logic en_b_o,
  output logic latch_o,
  output logic abort_o
);

  localparam int MAX_AB = (RST_CYC > ACQ_CYC) ? RST_CYC : ACQ_CYC;
  localparam int MAXC   = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
  localparam int CW     = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          win_q;
  logic          fall;
  logic          adv;

  // window edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else begin
      win_q <= win_i;
    end
  end

  assign rise_o = win_i & ~win_q;
  assign fall   = ~win_i & win_q;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    latch_o = 1'b0;
    abort_o = 1'b0;
    if (rise_o) begin
      st_d  = ST_CLR;
      cnt_d = '0;
    end else if (fall) begin
      cnt_d = '0;
      case (st_q)
        ST_HOLD: begin
          st_d    = ST_TAIL;
          latch_o = 1'b1;
        end
        ST_ACQA, ST_ACQB: begin
          st_d    = ST_TAIL;
          abort_o = 1'b1;
        end
        ST_CLR, ST_GAP: begin
          st_d    = ST_IDLE;
          abort_o = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end else begin
      case (st_q)
        ST_CLR: begin
          if (cnt_q == RST_LAST) begin
            st_d  = ST_ACQA;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_ACQA: begin
          if (cnt_q == ACQ_LAST) begin
            st_d  = ST_GAP;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_GAP: begin
          if (cnt_q == GAP_LAST) begin
            st_d  = ST_ACQB;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_ACQB: begin
          if (cnt_q == ACQ_LAST) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_HOLD: st_d = ST_HOLD;
        ST_TAIL: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign adv = (st_d != st_q) || (cnt_d != cnt_q);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (adv) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // phase decode
  assign strobe_o = (st_q == ST_ACQA) || (st_q == ST_ACQB) ||
                    (st_q == ST_HOLD) || (st_q == ST_TAIL);
  assign swap_o   = (st_q == ST_GAP);
  assign clr_a_o  = (st_q == ST_CLR);
  assign en_a_o   = (st_q == ST_ACQA);
  assign clr_b_o  = (st_q == ST_CLR) || (st_q == ST_GAP);
  assign en_b_o   = (st_q == ST_ACQB) || (st_q == ST_HOLD);

endmodule

// File: rtl/antsel_peak.sv
module antsel_peak #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [SW-1:0] smp_i,
  output logic [SW-1:0] pk_o
);

  logic [SW-1:0] pk_q, pk_d;
  logic          upd;

  always_comb begin
    upd  = 1'b0;
    pk_d = pk_q;
    if (clr_i) begin
      upd  = 1'b1;
      pk_d = '0;
    end else if (en_i && (smp_i > pk_q)) begin
      upd  = 1'b1;
      pk_d = smp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_q <= '0;
    end else if (upd) begin
      pk_q <= pk_d;
    end
  end

  assign pk_o = pk_q;

endmodule

// File: rtl/antsel_result.sv
module antsel_result (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic latch_i,
  input  logic abort_req_i,
  input  logic b_wins_i,
  output logic best_o,
  output logic abort_o
);

  logic best_q, best_d, best_en;
  logic abort_q;

  always_comb begin
    best_en = rise_i | latch_i;
    best_d  = rise_i ? 1'b0 : b_wins_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= 1'b0;
    end else if (best_en) begin
      best_q <= best_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
    end else begin
      abort_q <= abort_req_i;
    end
  end

  assign best_o  = best_q;
  assign abort_o = abort_q;

endmodule

// File: rtl/antsel_seq.sv
module antsel_seq #(
  parameter int SW      = 8,
  parameter int RST_CYC = 4,
  parameter int ACQ_CYC = 8,
  parameter int GAP_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_i,
  input  logic [SW-1:0] smp_i,
  output logic          strobe_o,
  output logic          swap_o,
  output logic          best_o,
  output logic          abort_o
);

  localparam int NPK = 2;

  logic          rst_sn;
  logic          rise, latch, abort_req;
  logic          clr_a, en_a, clr_b, en_b;
  logic [NPK-1:0] clr_v, en_v;
  logic [SW-1:0] pk_v [NPK];
  logic [SW-1:0] pk_a, pk_b;
  logic          b_wins;

  antsel_rstsync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_sn_o (rst_sn)
  );

  antsel_sched #(
    .RST_CYC (RST_CYC),
    .ACQ_CYC (ACQ_CYC),
    .GAP_CYC (GAP_CYC)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_sn),
    .win_i    (win_i),
    .rise_o   (rise),
    .strobe_o (strobe_o),
    .swap_o   (swap_o),
    .clr_a_o  (clr_a),
    .en_a_o   (en_a),
    .clr_b_o  (clr_b),
    .en_b_o   (en_b),
    .latch_o  (latch),
    .abort_o  (abort_req)
  );

  assign clr_v = {clr_b, clr_a};
  assign en_v  = {en_b, en_a};

  for (genvar g = 0; g < NPK; g++) begin : g_pk
    antsel_peak #(.SW(SW)) u_pk (
      .clk   (clk),
      .rst_n (rst_sn),
      .clr_i (clr_v[g]),
      .en_i  (en_v[g]),
      .smp_i (smp_i),
      .pk_o  (pk_v[g])
    );
  end

  assign pk_a   = pk_v[0];
  assign pk_b   = pk_v[1];
  assign b_wins = (pk_b > pk_a);

  antsel_result u_res (
    .clk         (clk),
    .rst_n       (rst_sn),
    .rise_i      (rise),
    .latch_i     (latch),
    .abort_req_i (abort_req),
    .b_wins_i    (b_wins),
    .best_o      (best_o),
    .abort_o     (abort_o)
  );

endmodule

// File: rtl/antsel_seq_chk.sv
module antsel_seq_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_i,
  input logic          strobe_o,
  input logic          swap_o,
  input logic          best_o,
  input logic          abort_o,
  input logic [SW-1:0] pk_a,
  input logic [SW-1:0] pk_b
);

  logic win_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_d <= 1'b0;
    end else begin
      win_d <= win_i;
    end
  end

  AST_RISE_CLEARS_BEST: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i && !win_d) |=> !best_o); // R2

  AST_SWAP_EXCL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_o && strobe_o)); // R4

  AST_SWAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> win_d); // R4

  AST_PEAK_A_HELD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> $stable(pk_a)); // R5

  AST_PEAK_B_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |=> (pk_b == '0)); // R6

  AST_BEST_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (win_i && win_d) |=> $stable(best_o)); // R7

  AST_BEST_STEADY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_i && !win_d) |=> $stable(best_o)); // R7

  AST_ABORT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o); // R8

  AST_ABORT_BEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !best_o); // R8

  AST_NO_LATE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_i && win_d && !strobe_o) |=> !strobe_o); // R9

endmodule

bind antsel_seq antsel_seq_chk #(.SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .win_i    (win_i),
  .strobe_o (strobe_o),
  .swap_o   (swap_o),
  .best_o   (best_o),
  .abort_o  (abort_o),
  .pk_a     (pk_a),
  .pk_b     (pk_b)
);

// File: tb/antsel_seq_tb.sv
module antsel_seq_tb;

  localparam int CLK_NS = 10;
  localparam int RSTC   = 4;
  localparam int ACQC   = 8;
  localparam int GAPC   = 4;
  localparam int A0     = RSTC + 1;
  localparam int B0     = RSTC + ACQC + GAPC + 1;
  localparam int PEND   = RSTC + 2 * ACQC + GAPC;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       win_i;
  logic [7:0] smp_i;
  logic       strobe_o, swap_o, best_o, abort_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  antsel_seq #(
    .SW      (8),
    .RST_CYC (RSTC),
    .ACQ_CYC (ACQC),
    .GAP_CYC (GAPC)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_i    (win_i),
    .smp_i    (smp_i),
    .strobe_o (strobe_o),
    .swap_o   (swap_o),
    .best_o   (best_o),
    .abort_o  (abort_o)
  );

  task automatic tick(input logic w, input logic [7:0] s);
    win_i = w;
    smp_i = s;
    @(posedge clk);
    #(CLK_NS / 4);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_strobe(input int k);
    return (k >= RSTC && k < RSTC + ACQC) || (k >= RSTC + ACQC + GAPC);
  endfunction

  function automatic bit exp_swap(input int k);
    return (k >= RSTC + ACQC) && (k < RSTC + ACQC + GAPC);
  endfunction

  // window of nhigh high edges, then a falling edge; keep=1 leaves the tail
  // clock for the next window to reopen in
  task automatic run_win(input logic [8*ACQC-1:0] a, input logic [8*ACQC-1:0] b,
                         input int nhigh, input logic [7:0] hval, input bit keep);
    int ma = 0;
    int mb = 0;
    logic [7:0] s;
    bit full;
    bit eb;
    for (int i = 0; i < ACQC; i++) begin
      if (int'(a[8*i +: 8]) > ma) ma = int'(a[8*i +: 8]);
      if (int'(b[8*i +: 8]) > mb) mb = int'(b[8*i +: 8]);
    end
    full = (nhigh > PEND);
    if (nhigh > PEND + 1 && int'(hval) > mb) mb = int'(hval);
    for (int k = 0; k < nhigh; k++) begin
      if (k >= A0 && k < A0 + ACQC)      s = a[8*(k-A0) +: 8];
      else if (k >= B0 && k < B0 + ACQC) s = b[8*(k-B0) +: 8];
      else if (k > PEND)                 s = hval;
      else                               s = 8'hFF;
      tick(1'b1, s);
      if (k == 0) chk(best_o == 1'b0, "R2", "best after rise", best_o, 0);
      chk(strobe_o == exp_strobe(k), "R3", "strobe in window", strobe_o, exp_strobe(k));
      chk(swap_o == exp_swap(k), "R4", "swap in window", swap_o, exp_swap(k));
    end
    tick(1'b0, 8'hFF);
    eb = full && (mb > ma);
    if (full) chk(best_o == eb, "R7", "decision (R5/R6 peaks)", best_o, eb);
    else      chk(best_o == 1'b0, "R8", "best after abort", best_o, 0);
    chk(abort_o == !full, "R8", "abort flag", abort_o, !full);
    chk(strobe_o == exp_strobe(nhigh - 1), "R9", "tail strobe", strobe_o,
        exp_strobe(nhigh - 1));
    if (!keep) begin
      tick(1'b0, 8'h00);
      chk(abort_o == 1'b0, "R8", "abort width", abort_o, 0);
      chk(strobe_o == 1'b0, "R9", "strobe after tail", strobe_o, 0);
      chk(best_o == eb, "R7", "best held after close", best_o, eb);
    end
  endtask

  task automatic t_reset;
    chk(best_o == 1'b0, "R1", "best", best_o, 0);
    chk(strobe_o == 1'b0, "R1", "strobe", strobe_o, 0);
    chk(swap_o == 1'b0, "R1", "swap", swap_o, 0);
    chk(abort_o == 1'b0, "R1", "abort", abort_o, 0);
  endtask

  task automatic t_a_wins;
    run_win(64'h1020_8030_0102_0304, 64'h4011_1213_1415_1617, PEND + 1, 8'h00, 1'b0);
  endtask

  task automatic t_b_then_reopen;
    run_win(64'h0102_0304_0506_0708, 64'h0910_6011_1213_1415, PEND + 1, 8'h00, 1'b1);
    chk(best_o == 1'b1, "R7", "B stronger", best_o, 1);
    // reopen in the tail clock: R2
    run_win(64'h7001_0203_0405_0607, 64'h2021_2223_2425_2627, PEND + 1, 8'h00, 1'b0);
  endtask

  task automatic t_equal;
    run_win(64'h5500_0000_0000_0011, 64'h0000_0055_0000_0000, PEND + 1, 8'h00, 1'b0);
    chk(best_o == 1'b0, "R7", "equal peaks", best_o, 0);
  endtask

  task automatic t_unsigned;
    run_win(64'h0000_0090_0000_0000, 64'h7F7F_7F7F_7F7F_7F7F, PEND + 1, 8'h00, 1'b0);
  endtask

  task automatic t_noise;
    // 0xFF arrives in reset interval and gap; must not reach either peak (R5, R6)
    run_win(64'h1010_1010_1010_1010, 64'h0020_0000_0000_0000, PEND + 1, 8'h00, 1'b0);
    chk(best_o == 1'b1, "R5", "noise ignored", best_o, 1);
  endtask

  task automatic t_hold;
    run_win(64'h0000_0050_0000_0000, 64'h0030_0000_0000_0000, PEND + 6, 8'h60, 1'b0);
    chk(best_o == 1'b1, "R6", "second peak follows hold", best_o, 1);
  endtask

  task automatic t_abort_last;
    run_win(64'h0102_0304_0506_0708, 64'h0910_6011_1213_1415, PEND + 1, 8'h00, 1'b0);
    run_win(64'h0000_0000_0000_0001, 64'hF0F0_F0F0_F0F0_F0F0, PEND, 8'h00, 1'b0);
  endtask

  task automatic t_abort_gap;
    run_win(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, RSTC + ACQC + 2, 8'h00, 1'b0);
  endtask

  task automatic t_abort_reset;
    run_win(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 2, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    win_i = 1'b0;
    smp_i = 8'h00;
    repeat (3) @(posedge clk);
    #(CLK_NS / 4);
    t_reset();
    rst_n = 1'b1;
    repeat (4) tick(1'b0, 8'h00);
    t_reset();
    t_a_wins();
    t_b_then_reopen();
    t_equal();
    t_unsigned();
    t_noise();
    t_hold();
    t_abort_last();
    t_abort_gap();
    t_abort_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule